// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a stored burst configuration and a starting column into the column address sequence of one SDRAM burst. It produces one address per clock. A mode-word load strobe captures the burst length, the ordering and the write-burst policy. A start strobe then launches a burst from a given column. A terminate strobe cuts a burst short. The outputs are the current column, a valid flag and a last-beat flag. A mode error flag reports a configuration the memory does not allow.

The block offers two orderings. Sequential ordering counts up within an aligned block and wraps inside it. Interleaved ordering XORs a beat index into the low column bits. The fixed lengths are 1, 2, 4 and 8. A full-page length also exists: it runs over the whole 256-column row, wraps at the end of the row, and only a terminate strobe or a new start stops it. A controller places this block beside its command sequencer and uses the valid column output to issue read and write column commands.

Top module: `burst_colgen`

## Requirements
- R1: While reset is asserted, and after it is released, `col_vld`, `col_last` and `mode_err` are low. The reset configuration is length 1, sequential order and normal write bursts.
- R2: A `mode_ld` pulse captures `mode_word` at the clock edge. Bits 2:0 select the length: 000=1, 001=2, 010=4, 011=8, 111=full page. The codes 100, 101 and 110 select length 1. Bit 3 selects the order: 0 is sequential, 1 is interleaved. Bit 9 selects single-write mode. Bits 8:4 have no effect on the bursts produced.
- R3: In the cycle after the edge that samples `start`, `col_vld` is high and `col_out` equals `start_col`. This is beat 0.
- R4: In a sequential burst of length N, beat k gives the upper column bits of the start column, with the low log2(N) bits equal to (start + k) mod N.
- R5: In an interleaved burst of length N, beat k gives the start column XOR k. Only the low log2(N) bits change.
- R6: A fixed-length burst raises `col_last` on beat N-1 only. `col_vld` drops in the next cycle unless a new start is sampled.
- R7: A full-page burst gives (start + k) mod 256 and never raises `col_last`. It runs until it is terminated.
- R8: Full page combined with interleave runs a sequential burst. `mode_err` is high for as long as that configuration is held, and it clears on the next load of a legal word.
- R9: When `term` is sampled high during a burst, and no start is sampled at the same edge, `col_vld` is low in the next cycle.
- R10: When single-write mode is set and `start_is_wr` is high at the start, the burst has length 1. Read bursts (`start_is_wr` low) keep the programmed length.
- R11: A start sampled during a burst abandons that burst and begins a new one at the new start column. A start takes priority over a terminate sampled at the same edge.
- R12: A burst uses the configuration held when it starts. A `mode_ld` during the burst does not change the remaining beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_ld | input | 1 | Load strobe for the mode word |
| mode_word | input | 10 | Burst configuration word |
| start | input | 1 | Starts a burst |
| start_col | input | 8 | Starting column for the burst |
| start_is_wr | input | 1 | The burst being started is a write |
| term | input | 1 | Terminates the current burst |
| col_out | output | 8 | Column of the current beat |
| col_vld | output | 1 | `col_out` holds a burst beat |
| col_last | output | 1 | Final beat of a fixed-length burst |
| mode_err | output | 1 | Illegal full-page interleave configuration is held |

## Verification
Random mode words and start columns go through every length code, including the reserved ones, both orderings and both write policies. Odd start columns separate the XOR order from the wrap-add order, because these two orders only differ once the start has nonzero low bits. Full-page bursts run for more than 256 beats from columns near the top of the row, so the wrap at the row end is tested. Directed cases cover situations that random traffic seldom reaches:
- a terminate in the middle of a fixed-length burst;
- a restart that arrives in the same cycle as a terminate;
- a mode load during a burst;
- the illegal full-page interleave word.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;
  localparam int unsigned COL_W       = 8;
  localparam int unsigned MODE_W      = 10;
  localparam int unsigned LEN_W       = 3;
  localparam int unsigned LEN_LSB     = 0;
  localparam int unsigned ORD_BIT     = 3;
  localparam int unsigned WBM_BIT     = 9;
  localparam int unsigned MAX_FIX_LOG = 3;
  localparam logic [LEN_W-1:0] LEN_FULL = '1;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } ord_e;
endpackage

// File: rtl/burst_mode_reg.sv
// Holds the burst configuration and decodes it into a column mask,
// a full-page flag, the effective ordering and the illegal-combination flag.
module burst_mode_reg
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W  = burst_colgen_pkg::COL_W,
  parameter int unsigned MODE_W = burst_colgen_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic [MODE_W-1:0] mode_word,
  output logic [COL_W-1:0]  cfg_mask,
  output logic              cfg_full,
  output ord_e              cfg_ord,
  output logic              cfg_single_wr,
  output logic              cfg_err
);

  logic [LEN_W-1:0] len_q, len_d;
  logic             ilv_q, ilv_d;
  logic             wbm_q, wbm_d;
  logic [COL_W-1:0] mask_fix;

  // latency and other bits are kept by the command side, not here
  logic unused_mode_bits;
  assign unused_mode_bits = ^mode_word[WBM_BIT-1:ORD_BIT+1];

  always_comb begin
    len_d = len_q;
    ilv_d = ilv_q;
    wbm_d = wbm_q;
    if (mode_ld) begin
      len_d = mode_word[LEN_LSB +: LEN_W];
      ilv_d = mode_word[ORD_BIT];
      wbm_d = mode_word[WBM_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      ilv_q <= 1'b0;
      wbm_q <= 1'b0;
    end else begin
      len_q <= len_d;
      ilv_q <= ilv_d;
      wbm_q <= wbm_d;
    end
  end

  // one mask bit per column bit: set below the programmed power of two
  for (genvar g = 0; g < COL_W; g++) begin : g_mask
    assign mask_fix[g] = (int'(len_q) <= MAX_FIX_LOG) && (int'(len_q) > g);
  end

  assign cfg_full      = (len_q == LEN_FULL);
  assign cfg_mask      = cfg_full ? '1 : mask_fix;
  assign cfg_ord       = (ilv_q && !cfg_full) ? ORD_ILV : ORD_SEQ;
  assign cfg_err       = ilv_q && cfg_full;
  assign cfg_single_wr = wbm_q;

endmodule

// File: rtl/burst_seq.sv
// Burst state: captures the effective settings at start and runs the beat counter.
module burst_seq
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W = burst_colgen_pkg::COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_is_wr,
  input  logic             term,
  input  logic [COL_W-1:0] cfg_mask,
  input  logic             cfg_full,
  input  ord_e             cfg_ord,
  input  logic             cfg_single_wr,
  output logic             run_active,
  output logic [COL_W-1:0] run_cnt,
  output logic [COL_W-1:0] run_base,
  output logic [COL_W-1:0] run_mask,
  output ord_e             run_ord,
  output logic             run_last
);

  logic             active_q, active_d;
  logic [COL_W-1:0] cnt_q, cnt_d;
  logic [COL_W-1:0] base_q, mask_q, mask_d;
  logic             full_q, full_d;
  ord_e             ord_q;
  logic             single;
  logic             last;

  assign single = start_is_wr && cfg_single_wr;
  assign last   = active_q && !full_q && (cnt_q == mask_q);
  assign mask_d = single ? '0 : cfg_mask;
  assign full_d = cfg_full && !single;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q && (term || last)) begin
      active_d = 1'b0;
    end else if (active_q) begin
      cnt_d    = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      ord_q    <= ORD_SEQ;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      if (start) begin
        base_q <= start_col;
        mask_q <= mask_d;
        full_q <= full_d;
        ord_q  <= cfg_ord;
      end
    end
  end

  assign run_active = active_q;
  assign run_cnt    = cnt_q;
  assign run_base   = base_q;
  assign run_mask   = mask_q;
  assign run_ord    = ord_q;
  assign run_last   = last;

endmodule

// File: rtl/burst_addr_map.sv
// Maps base column and beat index to the beat's column, bit by bit.
module burst_addr_map
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W = burst_colgen_pkg::COL_W
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  ord_e             ord,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] sum;
  assign sum = base + cnt;

  for (genvar g = 0; g < COL_W; g++) begin : g_bit
    logic seq_bit;
    logic ilv_bit;
    assign seq_bit = mask[g] ? sum[g] : base[g];
    assign ilv_bit = base[g] ^ (cnt[g] & mask[g]);
    assign col[g]  = (ord == ORD_ILV) ? ilv_bit : seq_bit;
  end

endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W  = burst_colgen_pkg::COL_W,
  parameter int unsigned MODE_W = burst_colgen_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ld,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              start_is_wr,
  input  logic              term,
  output logic [COL_W-1:0]  col_out,
  output logic              col_vld,
  output logic              col_last,
  output logic              mode_err
);

  logic [COL_W-1:0] cfg_mask;
  logic             cfg_full;
  ord_e             cfg_ord;
  logic             cfg_single_wr;
  logic [COL_W-1:0] run_cnt, run_base, run_mask;
  ord_e             run_ord;

  burst_mode_reg #(.COL_W(COL_W), .MODE_W(MODE_W)) u_mode (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_ld       (mode_ld),
    .mode_word     (mode_word),
    .cfg_mask      (cfg_mask),
    .cfg_full      (cfg_full),
    .cfg_ord       (cfg_ord),
    .cfg_single_wr (cfg_single_wr),
    .cfg_err       (mode_err)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_col     (start_col),
    .start_is_wr   (start_is_wr),
    .term          (term),
    .cfg_mask      (cfg_mask),
    .cfg_full      (cfg_full),
    .cfg_ord       (cfg_ord),
    .cfg_single_wr (cfg_single_wr),
    .run_active    (col_vld),
    .run_cnt       (run_cnt),
    .run_base      (run_base),
    .run_mask      (run_mask),
    .run_ord       (run_ord),
    .run_last      (col_last)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base (run_base),
    .cnt  (run_cnt),
    .mask (run_mask),
    .ord  (run_ord),
    .col  (col_out)
  );

endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk
  import burst_colgen_pkg::*;
#(
  parameter int unsigned COL_W  = burst_colgen_pkg::COL_W,
  parameter int unsigned MODE_W = burst_colgen_pkg::MODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_ld,
  input logic [MODE_W-1:0] mode_word,
  input logic              start,
  input logic [COL_W-1:0]  start_col,
  input logic              term,
  input logic [COL_W-1:0]  col_out,
  input logic              col_vld,
  input logic              col_last,
  input logic              mode_err
);

  logic bad_word;
  assign bad_word = (mode_word[LEN_LSB +: LEN_W] == LEN_FULL) && mode_word[ORD_BIT];

  // R3
  start_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_vld && col_out == $past(start_col)));

  // R6
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_vld);

  // R6
  last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_vld);

  // R9
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_vld && term && !start) |=> !col_vld);

  // R8
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ld && bad_word) |=> mode_err);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ld && !bad_word) |=> !mode_err);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_vld && !start) |=> !col_vld);

endmodule

bind burst_colgen burst_colgen_chk #(.COL_W(COL_W), .MODE_W(MODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_ld   (mode_ld),
  .mode_word (mode_word),
  .start     (start),
  .start_col (start_col),
  .term      (term),
  .col_out   (col_out),
  .col_vld   (col_vld),
  .col_last  (col_last),
  .mode_err  (mode_err)
);

// File: tb/burst_colgen_test.sv
module burst_colgen_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_ld;
  logic [9:0] mode_word;
  logic       start;
  logic [7:0] start_col;
  logic       start_is_wr;
  logic       term;
  logic [7:0] col_out;
  logic       col_vld;
  logic       col_last;
  logic       mode_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int m_lg;
  bit m_full, m_ilv, m_err, m_wbm;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_colgen uut (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_is_wr(start_is_wr), .term(term),
    .col_out(col_out), .col_vld(col_vld), .col_last(col_last), .mode_err(mode_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_col(input logic [7:0] sc, input int k,
                                          input int lg, input bit full, input bit ilv);
    logic [7:0] mask;
    logic [7:0] kk;
    kk   = 8'(k);
    mask = full ? 8'hFF : 8'((1 << lg) - 1);
    if (ilv && !full) return sc ^ (kk & mask);
    return (sc & ~mask) | ((sc + kk) & mask);
  endfunction

  function automatic void decode(input logic [9:0] w);
    m_full = (w[2:0] == 3'b111);
    m_lg   = (w[2:0] <= 3'd3) ? int'(w[2:0]) : 0;
    m_ilv  = w[3] && !m_full;
    m_err  = w[3] && m_full;
    m_wbm  = w[9];
  endfunction

  task automatic load_mode(input logic [9:0] w);
    @(negedge clk);
    mode_ld = 1'b1; mode_word = w;
    @(negedge clk);
    mode_ld = 1'b0;
    decode(w);
    check(mode_err == m_err, "R8 mode_err", int'(mode_err), int'(m_err));
  endtask

  // beat 0 is visible at the current negedge
  task automatic run_beats(input logic [7:0] sc, input bit wr, input int full_beats);
    bit single;
    int lg;
    bit full;
    int n;
    string tag;
    single = wr && m_wbm;
    lg     = single ? 0 : m_lg;
    full   = single ? 1'b0 : m_full;
    n      = full ? full_beats : (1 << lg);
    tag    = single ? "R10" : (full ? "R7" : (m_ilv ? "R5" : "R4"));
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = exp_col(sc, k, lg, full, m_ilv);
      check(col_vld == 1'b1, {tag, " vld"}, int'(col_vld), 1);
      check(col_out == e, {tag, " col"}, int'(col_out), int'(e));
      check(col_last == (!full && k == n - 1), "R6 last", int'(col_last),
            int'(!full && k == n - 1));
      if (full && k == n - 1) term = 1'b1;
      @(negedge clk);
      term = 1'b0;
    end
    check(col_vld == 1'b0, full ? "R9 end" : "R6 end", int'(col_vld), 0);
  endtask

  task automatic burst(input logic [7:0] sc, input bit wr, input int full_beats);
    @(negedge clk);
    start = 1'b1; start_col = sc; start_is_wr = wr;
    @(negedge clk);
    start = 1'b0;
    run_beats(sc, wr, full_beats);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mode_ld = 1'b0; mode_word = '0; start = 1'b0;
    start_col = '0; start_is_wr = 1'b0; term = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(col_vld == 1'b0 && col_last == 1'b0 && mode_err == 1'b0, "R1 in reset",
          int'({col_vld, col_last, mode_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(col_vld == 1'b0 && col_last == 1'b0 && mode_err == 1'b0, "R1 after reset",
          int'({col_vld, col_last, mode_err}), 0);
    decode(10'h000);
    burst(8'h5A, 1'b0, 1); // R1 default length 1

    // R2 reserved code and ignored bits
    load_mode(10'h005);
    burst(8'h13, 1'b0, 1);
    load_mode(10'h1F2);
    burst(8'h2D, 1'b0, 1);
    load_mode(10'h00B);
    burst(8'h6D, 1'b0, 1); // R5 odd start interleave

    // R8 full page + interleave runs sequential
    load_mode(10'h00F);
    burst(8'hF8, 1'b0, 20);
    load_mode(10'h007);
    burst(8'hFE, 1'b0, 300); // R7 row wrap

    // R10 single write
    load_mode(10'h202);
    burst(8'h47, 1'b1, 1);
    burst(8'h47, 1'b0, 1);

    // R12 mode load during a burst
    load_mode(10'h003);
    @(negedge clk);
    start = 1'b1; start_col = 8'h35; start_is_wr = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] e;
      e = exp_col(8'h35, k, 3, 1'b0, 1'b0);
      check(col_out == e && col_vld, "R12 col", int'(col_out), int'(e));
      if (k == 1) begin mode_ld = 1'b1; mode_word = 10'h009; end
      @(negedge clk);
      mode_ld = 1'b0;
    end
    check(col_vld == 1'b0, "R12 end", int'(col_vld), 0);
    decode(10'h009);
    burst(8'h35, 1'b0, 1);

    // R11 restart with simultaneous terminate
    load_mode(10'h003);
    @(negedge clk);
    start = 1'b1; start_col = 8'h10; start_is_wr = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check(col_out == exp_col(8'h10, k, 3, 1'b0, 1'b0), "R11 first", int'(col_out),
            int'(exp_col(8'h10, k, 3, 1'b0, 1'b0)));
      if (k == 2) begin start = 1'b1; start_col = 8'h22; term = 1'b1; end
      @(negedge clk);
      start = 1'b0; term = 1'b0;
    end
    run_beats(8'h22, 1'b0, 1);

    // R9 terminate a fixed burst
    @(negedge clk);
    start = 1'b1; start_col = 8'h40;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(col_vld == 1'b1, "R9 running", int'(col_vld), 1);
      if (k == 3) term = 1'b1;
      @(negedge clk);
      term = 1'b0;
    end
    check(col_vld == 1'b0, "R9 stopped", int'(col_vld), 0);

    // random traffic
    for (int i = 0; i < 60; i++) begin
      logic [9:0] w;
      w = 10'($urandom);
      if ($urandom % 3 == 0) w[2:0] = 3'b111;
      load_mode(w);
      burst(8'($urandom), 1'($urandom), 1 + int'($urandom % 300));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule